// File: doc/BRIEF.md
# Address-Pattern RAM Self-Test Engine

This block is a power-on self-test controller for a small page of synchronous single-port RAM. It owns the RAM's address, write-data and write-enable lines and watches its read data. After a one-cycle start pulse it makes several full sweeps over the page, then raises a done flag together with a pass/fail result.

The first sweep stores each cell's own address in that cell. The second sweep increments every cell in place and checks for address plus one. Together these expose shorted or missing address lines, such as half the page answering at two addresses, which a plain data pattern would not reveal. A write-only sweep then fills the page with alternating all-ones and all-zeros bytes, and a read-only sweep checks that pattern to catch coupling between neighbouring cells. The last sweep reads each byte, writes back its complement and checks that the complement reads back.

The first mismatch ends the run at once. The engine then holds the failing address, the expected byte and the byte it observed on its outputs until the next start.

Top module: `ramst_engine`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, busy, done and fail are 0 and ram_we is 0.
- R2: The first sweep writes the value of each address to that address, issues a read one cycle later, and compares the read data in the following cycle (one cycle of read latency). The expected value is the address itself.
- R3: The second sweep reads each cell, writes back the read value plus one (modulo 256), re-reads it and expects address plus one modulo 256, whatever value was read.
- R4: The third sweep writes 0xFF to every even address and 0x00 to every odd address, with no compare. The fourth sweep then reads every cell back and expects that same pattern.
- R5: The fifth sweep reads each cell, writes back the bitwise complement of the value read, re-reads it and expects that complement.
- R6: Every sweep visits all 256 addresses, 0x00 to 0xFF, in ascending order, and moves on only when the 8-bit address wraps from 0xFF to 0x00. A passing run makes exactly 1024 writes and takes 4096 cycles from the start edge to done.
- R7: A mismatch ends the run at once with done=1 and fail=1. No later address is visited and no further write occurs.
- R8: On a failure, fail_addr, fail_exp and fail_obs hold the failing address, the expected byte and the observed byte.
- R9: A start pulse while busy is ignored. The run continues unchanged and still makes exactly 1024 writes.
- R10: Done, fail and the failure outputs stay stable until the next start. A start while done clears done and begins a new run in the next cycle.
- R11: After a passing run the RAM holds 0x00 at every even address and 0xFF at every odd address.
- R12: A page whose upper half aliases onto its lower half is reported as a failure at address 0x00, with expected 0x01 and observed 0x81.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; acted on only when the engine is not busy |
| ram_addr | output | 8 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | 8 | RAM read data, valid one cycle after the address is issued |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The run has ended; held until the next start |
| fail | output | 1 | The run ended on a mismatch |
| fail_addr | output | 8 | Address of the failing compare |
| fail_exp | output | 8 | Expected byte at the failing compare |
| fail_obs | output | 8 | Byte read back at the failing compare |

## Verification
The hardest situations to reach are the failures that only a later sweep can see. An aliased page passes the address sweep completely and shows up only on the increment sweep. A cell that cannot hold 0x00 is caught only by the complement sweep. To reach these cases, the bench's RAM model injects one fault per run: upper-half aliasing, a write bit stuck low, a read bit stuck high, a cell pulled high when its even neighbour is written with 0xFF, a transition fault at 0x9C, and a dead cell at 0xFF. For each fault the bench works out by hand the failing address, the expected and observed bytes and the number of writes before the stop.

// File: rtl/ramst_pkg.sv
package ramst_pkg;

   typedef enum logic [2:0] {
      PH_ADDR = 3'd0,
      PH_INC  = 3'd1,
      PH_ALTW = 3'd2,
      PH_ALTR = 3'd3,
      PH_INV  = 3'd4
   } phase_t;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_FETCH = 3'd1,
      ST_HOLD  = 3'd2,
      ST_WR    = 3'd3,
      ST_RD    = 3'd4,
      ST_CMP   = 3'd5
   } step_t;

   function automatic phase_t next_phase(input phase_t p);
      case (p)
         PH_ADDR: return PH_INC;
         PH_INC:  return PH_ALTW;
         PH_ALTW: return PH_ALTR;
         PH_ALTR: return PH_INV;
         default: return PH_INV;
      endcase
   endfunction

   function automatic step_t first_step(input phase_t p);
      case (p)
         PH_ADDR: return ST_WR;
         PH_INC:  return ST_FETCH;
         PH_ALTW: return ST_WR;
         PH_ALTR: return ST_RD;
         default: return ST_FETCH;
      endcase
   endfunction

endpackage

// File: rtl/ramst_addr_seq.sv
module ramst_addr_seq #(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          adv,
   output logic [AW-1:0] addr,
   output logic          last
);

   localparam logic [AW-1:0] TOP_ADDR = {AW{1'b1}};

   logic [AW:0] sum;

   assign sum  = {1'b0, addr} + {{AW{1'b0}}, 1'b1};
   assign last = sum[AW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr <= '0;
      else if (clr)
         addr <= '0;
      else if (adv)
         addr <= sum[AW-1:0];
   end

   // R6
   step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !clr && addr != TOP_ADDR) |=> (addr == $past(addr) + 1'b1));

   // R6
   wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !clr && addr == TOP_ADDR) |=> (addr == '0));

endmodule

// File: rtl/ramst_pattern.sv
module ramst_pattern
   import ramst_pkg::*;
#(
   parameter int AW        = 8,
   parameter int DW        = 8,
   parameter bit EVEN_ONES = 1'b1
) (
   input  phase_t        phase,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] hold,
   output logic [DW-1:0] wdata,
   output logic [DW-1:0] expect_val
);

   logic [DW-1:0] addr_ext;
   logic [DW-1:0] alt_val;

   assign addr_ext = DW'(addr);

   generate
      if (EVEN_ONES) begin : g_even_ones
         assign alt_val = addr[0] ? {DW{1'b0}} : {DW{1'b1}};
      end else begin : g_even_zeros
         assign alt_val = addr[0] ? {DW{1'b1}} : {DW{1'b0}};
      end
   endgenerate

   always_comb begin
      wdata      = addr_ext;
      expect_val = addr_ext;
      case (phase)
         PH_ADDR: begin
            wdata      = addr_ext;
            expect_val = addr_ext;
         end
         PH_INC: begin
            wdata      = hold + 1'b1;
            expect_val = addr_ext + 1'b1;
         end
         PH_ALTW, PH_ALTR: begin
            wdata      = alt_val;
            expect_val = alt_val;
         end
         default: begin
            wdata      = ~hold;
            expect_val = ~hold;
         end
      endcase
   end

endmodule

// File: rtl/ramst_result.sv
module ramst_result #(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          cmp_en,
   input  logic          finish_ok,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] expect_val,
   input  logic [DW-1:0] rdata,
   output logic          mismatch,
   output logic          done,
   output logic          fail,
   output logic [AW-1:0] fail_addr,
   output logic [DW-1:0] fail_exp,
   output logic [DW-1:0] fail_obs
);

   assign mismatch = cmp_en && (rdata != expect_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done      <= 1'b0;
         fail      <= 1'b0;
         fail_addr <= '0;
         fail_exp  <= '0;
         fail_obs  <= '0;
      end else if (clr) begin
         done      <= 1'b0;
         fail      <= 1'b0;
         fail_addr <= '0;
         fail_exp  <= '0;
         fail_obs  <= '0;
      end else if (mismatch) begin
         done      <= 1'b1;
         fail      <= 1'b1;
         fail_addr <= addr;
         fail_exp  <= expect_val;
         fail_obs  <= rdata;
      end else if (finish_ok) begin
         done      <= 1'b1;
      end
   end

   // R8
   fail_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail) |-> (done && fail_exp != fail_obs));

   // R10
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !clr) |=> (done && $stable(fail) && $stable(fail_addr)
                          && $stable(fail_exp) && $stable(fail_obs)));

endmodule

// File: rtl/ramst_engine.sv
module ramst_engine
   import ramst_pkg::*;
#(
   parameter int AW        = 8,
   parameter int DW        = 8,
   parameter bit EVEN_ONES = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic [AW-1:0] ram_addr,
   output logic [DW-1:0] ram_wdata,
   output logic          ram_we,
   input  logic [DW-1:0] ram_rdata,
   output logic          busy,
   output logic          done,
   output logic          fail,
   output logic [AW-1:0] fail_addr,
   output logic [DW-1:0] fail_exp,
   output logic [DW-1:0] fail_obs
);

   localparam logic [AW-1:0] TOP_ADDR = {AW{1'b1}};

   generate
      if (AW < 1) begin : g_bad_aw
         $error("ramst_engine: AW must be at least 1");
      end
      if (DW < AW) begin : g_bad_dw
         $error("ramst_engine: DW must not be narrower than AW");
      end
   endgenerate

   step_t         step;
   step_t         after_step;
   phase_t        phase;
   logic [DW-1:0] hold;
   logic [AW-1:0] addr;
   logic          last;
   logic          start_ok;
   logic          adv;
   logic          finish_ok;
   logic          mismatch;
   logic          cmp_en;
   logic [DW-1:0] expect_val;

   assign start_ok  = start && (step == ST_IDLE);
   assign cmp_en    = (step == ST_CMP);
   assign adv       = ((step == ST_WR) && (phase == PH_ALTW)) ||
                      (cmp_en && !mismatch);
   assign finish_ok = adv && last && (phase == PH_INV);

   always_comb begin
      if (last)
         after_step = (phase == PH_INV) ? ST_IDLE : first_step(next_phase(phase));
      else
         after_step = first_step(phase);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step  <= ST_IDLE;
         phase <= PH_ADDR;
         hold  <= '0;
      end else begin
         case (step)
            ST_IDLE: begin
               if (start_ok) begin
                  phase <= PH_ADDR;
                  step  <= first_step(PH_ADDR);
               end
            end
            ST_FETCH: step <= ST_HOLD;
            ST_HOLD: begin
               hold <= ram_rdata;
               step <= ST_WR;
            end
            ST_WR: step <= (phase == PH_ALTW) ? after_step : ST_RD;
            ST_RD: step <= ST_CMP;
            ST_CMP: step <= mismatch ? ST_IDLE : after_step;
            default: step <= ST_IDLE;
         endcase
         if (adv && last && phase != PH_INV)
            phase <= next_phase(phase);
      end
   end

   ramst_addr_seq #(.AW(AW)) i_addr_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start_ok),
      .adv   (adv),
      .addr  (addr),
      .last  (last)
   );

   ramst_pattern #(.AW(AW), .DW(DW), .EVEN_ONES(EVEN_ONES)) i_pattern (
      .phase      (phase),
      .addr       (addr),
      .hold       (hold),
      .wdata      (ram_wdata),
      .expect_val (expect_val)
   );

   ramst_result #(.AW(AW), .DW(DW)) i_result (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (start_ok),
      .cmp_en     (cmp_en),
      .finish_ok  (finish_ok),
      .addr       (addr),
      .expect_val (expect_val),
      .rdata      (ram_rdata),
      .mismatch   (mismatch),
      .done       (done),
      .fail       (fail),
      .fail_addr  (fail_addr),
      .fail_exp   (fail_exp),
      .fail_obs   (fail_obs)
   );

   assign ram_addr = addr;
   assign ram_we   = (step == ST_WR);
   assign busy     = (step != ST_IDLE);

   // R7
   quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !ram_we);

   // R7
   stop_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mismatch |=> (!busy && done && fail));

   // R10
   done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && busy));

   // R6
   sweep_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && phase != $past(phase)) |-> ($past(addr) == TOP_ADDR));

endmodule

// File: tb/test_ramst_engine.sv
module test_ramst_engine;

   localparam int CLK_PERIOD = 10;
   localparam int TIMEOUT    = 20000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] ram_addr;
   logic [7:0] ram_wdata;
   logic       ram_we;
   logic [7:0] ram_rdata;
   logic       busy, done, fail;
   logic [7:0] fail_addr, fail_exp, fail_obs;

   int checks = 0;
   int failures = 0;
   int fault_mode = 0;
   logic fill_req = 1'b0;
   int wr_count = 0;
   logic [7:0] mem [256];

   always #(CLK_PERIOD/2) clk = ~clk;

   ramst_engine i_ramst_engine (
      .clk(clk), .rst_n(rst_n), .start(start),
      .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
      .ram_rdata(ram_rdata), .busy(busy), .done(done), .fail(fail),
      .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_obs(fail_obs)
   );

   // fault modes: 0 none, 1 upper half aliases lower, 2 write bit3 stuck 0,
   // 3 read bit7 stuck 1, 4 even 0xFF write pulls lower odd neighbour,
   // 5 cell 0x9C stores 0x01 for 0x00, 6 cell 0xFF ignores writes
   function automatic logic [7:0] phys(input logic [7:0] a);
      return (fault_mode == 1) ? {1'b0, a[6:0]} : a;
   endfunction

   function automatic logic [7:0] wr_val(input logic [7:0] a, input logic [7:0] d);
      logic [7:0] v = d;
      if (fault_mode == 2) v[3] = 1'b0;
      if (fault_mode == 5 && a == 8'h9C && d == 8'h00) v = 8'h01;
      return v;
   endfunction

   always @(posedge clk) begin
      if (fill_req) begin
         for (int i = 0; i < 256; i++) mem[i] <= 8'h5A;
      end else if (ram_we) begin
         wr_count <= wr_count + 1;
         if (!(fault_mode == 6 && ram_addr == 8'hFF))
            mem[phys(ram_addr)] <= wr_val(ram_addr, ram_wdata);
         if (fault_mode == 4 && ram_wdata == 8'hFF && !ram_addr[0])
            mem[ram_addr - 8'd1] <= 8'hFF;
      end
      ram_rdata <= mem[phys(ram_addr)] | ((fault_mode == 3) ? 8'h80 : 8'h00);
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic prep(input int mode);
      @(negedge clk) begin fault_mode = mode; fill_req = 1'b1; end
      @(negedge clk) fill_req = 1'b0;
   endtask

   task automatic wait_done(output int cyc);
      cyc = 0;
      while (!done) begin
         @(negedge clk);
         cyc++;
         if (cyc > TIMEOUT) begin
            checks++;
            failures++;
            $display("FAIL R6 watchdog actual=%0d expected<=%0d", cyc, TIMEOUT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   endtask

   task automatic fault_run(input int mode, input string req, input int f_addr,
                            input int f_exp, input int f_obs, input int nwr);
      int cyc;
      int base;
      prep(mode);
      base = wr_count;
      pulse_start();
      wait_done(cyc);
      check(req, "fail flag", fail, 1);
      check("R8", "fail_addr", fail_addr, f_addr);
      check("R8", "fail_exp", fail_exp, f_exp);
      check("R8", "fail_obs", fail_obs, f_obs);
      check("R7", "writes before stop", wr_count - base, nwr);
      repeat (20) @(negedge clk);
      check("R7", "no writes after stop", wr_count - base, nwr);
      check("R10", "fail_addr held", fail_addr, f_addr);
   endtask

   initial begin
      int cyc;
      int base;
      int bad;
      repeat (3) @(negedge clk);
      check("R1", "busy in reset", busy, 0);
      check("R1", "done in reset", done, 0);
      check("R1", "we in reset", ram_we, 0);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      check("R1", "busy after reset", busy, 0);
      check("R1", "done after reset", done, 0);
      check("R1", "fail after reset", fail, 0);
      check("R1", "we after reset", ram_we, 0);

      // clean run with a second start while busy
      prep(0);
      base = wr_count;
      pulse_start();
      repeat (100) @(negedge clk);
      pulse_start();
      wait_done(cyc);
      check("R9", "fail after ignored start", fail, 0);
      check("R9", "writes with ignored start", wr_count - base, 1024);

      repeat (40) @(negedge clk);
      check("R10", "done held", done, 1);
      check("R10", "fail held", fail, 0);
      bad = 0;
      for (int i = 0; i < 256; i++)
         if (mem[i] != ((i % 2) ? 8'hFF : 8'h00)) bad++;
      check("R11", "cells off final pattern", bad, 0);

      // rerun from done: timing and coverage of all sweeps
      prep(0);
      base = wr_count;
      pulse_start();
      check("R10", "busy after restart", busy, 1);
      check("R10", "done cleared by restart", done, 0);
      wait_done(cyc);
      check("R6", "cycles start to done", cyc, 4096);
      check("R6", "writes in passing run", wr_count - base, 1024);
      check("R2", "passing run fail flag", fail, 0);
      check("R3", "passing run fail_obs cleared", fail_obs, 0);

      fault_run(1, "R12", 8'h00, 8'h01, 8'h81, 257);
      fault_run(2, "R2", 8'h08, 8'h08, 8'h00, 9);
      fault_run(3, "R2", 8'h00, 8'h00, 8'h80, 1);
      fault_run(4, "R4", 8'h01, 8'h00, 8'hFF, 768);
      fault_run(5, "R5", 8'h9C, 8'h00, 8'h01, 925);
      fault_run(6, "R6", 8'hFF, 8'hFF, 8'h5A, 256);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule